// File: doc/BRIEF.md
# Vector Element Halfword Store Unit

This unit carries out one kind of store. It writes one 16-bit element of a 128-bit vector register to memory. An instruction word arrives on a valid/ready input together with three values already read from the register files: a base value, an index value and the source vector. The unit also decodes the register numbers from the word, so a neighbouring register file can look them up in the same cycle.

When the word is recognised, the unit adds base and index and keeps the low 32 bits as the effective address. The halfword slot of the vector is the one that lines up with that address inside a 16-byte line. The unit places that slot's two bytes most-significant-first at the half-aligned position in the line. It then issues one write request on a 16-byte port whose byte strobe has exactly two bits set. If load-reservation tracking is on and holds an active reservation, an invalidate for the written address goes out in the same cycle as the write handshake. A completion pulse reports the next program counter, or it flags the word as illegal when the word is not recognised.

Top module: `vhs_store_unit`

## Requirements
- R1: The word is recognised when bits [31:26] equal 31 and bits [10:1] equal 167 (for example 0x7C00014E with all register fields zero). Bit 0 does not take part. The vector, base and index register numbers are bits [25:21], [20:16] and [15:11], and they appear on `fld_vs`, `fld_ra` and `fld_rb` while the word is presented.
- R2: A base register number of 0 makes the base operand zero, whatever value `ra_val` carries.
- R3: The effective address (EA) is (base + `rb_val`) modulo 2^64, truncated to its low 32 bits.
- R4: `mem_addr` is the EA with its low four bits cleared.
- R5: The element stored is halfword slot EA[3:1] of the vector. Vector byte 0 is `vs_val[127:120]`, so slot L is `vs_val[127-16L -: 16]`.
- R6: `mem_strb` has exactly bits o and o+1 set, where o = EA & 0xE. Strobe bit k and data bits [8k+7:8k] belong to address `mem_addr`+k.
- R7: Port byte o carries the high byte of the slot and byte o+1 carries the low byte. All data bytes outside the strobe are zero.
- R8: `inv_valid` is high in the cycle of the write handshake, and only then, when `resv_enable` and `resv_any_active` were both high when the word was accepted. `inv_addr` is the EA with bit 0 cleared.
- R9: A write request holds its address, data and strobe stable until `mem_ready`. `in_ready` stays low while a request is pending.
- R10: One cycle after the write handshake, `done_valid` pulses with `done_illegal` low and `done_next_pc` equal to the word's PC plus 4.
- R11: An unrecognised word produces no write and no invalidate. The cycle after it is accepted, `done_valid` pulses with `done_illegal` high and `done_next_pc` equal to the unchanged PC.
- R12: After reset, `in_ready` is high and `mem_valid`, `inv_valid` and `done_valid` are low.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Unit can accept a word |
| in_instr | input | 32 | Instruction word |
| in_pc | input | 32 | Address of the instruction |
| ra_val | input | 64 | Value of the base register |
| rb_val | input | 64 | Value of the index register |
| vs_val | input | 128 | Source vector, byte 0 in the top bits |
| resv_enable | input | 1 | Reservation tracking switched on |
| resv_any_active | input | 1 | At least one reservation held |
| fld_vs | output | 5 | Decoded vector register number |
| fld_ra | output | 5 | Decoded base register number |
| fld_rb | output | 5 | Decoded index register number |
| mem_valid | output | 1 | Write request pending |
| mem_ready | input | 1 | Memory takes the write |
| mem_addr | output | 32 | Line-aligned write address |
| mem_data | output | 128 | Write data, byte k in bits [8k+7:8k] |
| mem_strb | output | 16 | Byte enables |
| inv_valid | output | 1 | Reservation invalidate pulse |
| inv_addr | output | 32 | Half-aligned address to invalidate |
| done_valid | output | 1 | Instruction completed |
| done_illegal | output | 1 | Completed word was not recognised |
| done_next_pc | output | 32 | Next program counter |

## Verification
A wrong slot index or a slip in byte order shows up in `mem_data` or `mem_strb` on the first write request after the word is accepted, one cycle later. A swapped byte pair needs a source vector whose two bytes differ. A base operand that has lost its zero override, or a carry that escapes the truncation, moves `mem_addr` or the strobe position in that same cycle. A reservation flag captured at the wrong time shows only at the handshake, through `inv_valid`, while a stalled port holds the request open. A completion register that is off by one cycle or by four bytes shows on `done_valid` and `done_next_pc` in the cycle right after the handshake.

// File: rtl/vhs_pkg.sv
package vhs_pkg;
   localparam logic [5:0] PRIMARY_OP = 6'd31;
   localparam logic [9:0] EXT_OP     = 10'd167;
   localparam int         INSTR_W    = 32;
   localparam int         REG_IDX_W  = 5;

   typedef struct packed {
      logic [5:0]           opcd;
      logic [REG_IDX_W-1:0] vs;
      logic [REG_IDX_W-1:0] ra;
      logic [REG_IDX_W-1:0] rb;
      logic [9:0]           xo;
      logic                 rc;
   } vhs_word_t;
endpackage

// File: rtl/vhs_decode.sv
module vhs_decode
   import vhs_pkg::*;
(
   input  logic [INSTR_W-1:0]   instr,
   output logic [REG_IDX_W-1:0] vs_idx,
   output logic [REG_IDX_W-1:0] ra_idx,
   output logic [REG_IDX_W-1:0] rb_idx,
   output logic                 match
);
   vhs_word_t w;
   logic      unused_rc;

   assign w         = vhs_word_t'(instr);
   assign vs_idx    = w.vs;
   assign ra_idx    = w.ra;
   assign rb_idx    = w.rb;
   assign match     = (w.opcd == PRIMARY_OP) && (w.xo == EXT_OP);
   assign unused_rc = w.rc;
endmodule

// File: rtl/vhs_agen.sv
module vhs_agen #(
   parameter int XLEN = 64,
   parameter int AW   = 32
) (
   input  logic            base_zero,
   input  logic [XLEN-1:0] base_val,
   input  logic [XLEN-1:0] index_val,
   output logic [AW-1:0]   ea
);
   logic [XLEN-1:0] base_op;
   logic [XLEN-1:0] sum;

   if (AW > XLEN || AW < 4) begin : g_bad_aw
      $error("vhs_agen: AW must lie between 4 and XLEN");
   end

   assign base_op = base_zero ? '0 : base_val;
   assign sum     = base_op + index_val;
   assign ea      = sum[AW-1:0];

   if (AW < XLEN) begin : g_trunc
      logic unused_hi;
      assign unused_hi = ^sum[XLEN-1:AW];
   end
endmodule

// File: rtl/vhs_place.sv
module vhs_place #(
   parameter int AW        = 32,
   parameter int VW        = 128,
   parameter int EB        = 2,
   parameter bit ZERO_FILL = 1'b1
) (
   input  logic [AW-1:0]   ea,
   input  logic [VW-1:0]   vec,
   output logic [AW-1:0]   line_addr,
   output logic [AW-1:0]   elem_addr,
   output logic [VW-1:0]   data,
   output logic [VW/8-1:0] strb
);
   localparam int SB   = VW / 8;
   localparam int OFFW = $clog2(SB);
   localparam int EW   = $clog2(EB);

   logic [OFFW-1:0] lane;

   if (VW % 8 != 0 || (SB & (SB - 1)) != 0) begin : g_bad_vw
      $error("vhs_place: VW must be a power-of-two number of bytes");
   end
   if ((EB & (EB - 1)) != 0 || EB > SB) begin : g_bad_eb
      $error("vhs_place: EB must be a power of two no wider than the line");
   end

   assign line_addr = ea & ~AW'(SB - 1);
   assign elem_addr = ea & ~AW'(EB - 1);
   assign lane      = ea[OFFW-1:0] >> EW;

   for (genvar k = 0; k < SB; k++) begin : g_byte
      localparam int SLOT = k / EB;
      logic [7:0] vbyte;
      assign vbyte   = vec[VW-1-8*k -: 8];
      assign strb[k] = (lane == OFFW'(SLOT));
      if (ZERO_FILL) begin : g_zero
         assign data[8*k +: 8] = strb[k] ? vbyte : 8'h00;
      end else begin : g_pass
         assign data[8*k +: 8] = vbyte;
      end
   end
endmodule

// File: rtl/vhs_store_unit.sv
module vhs_store_unit
   import vhs_pkg::*;
#(
   parameter int XLEN      = 64,
   parameter int AW        = 32,
   parameter int VW        = 128,
   parameter int EB        = 2,
   parameter bit ZERO_FILL = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   output logic                 in_ready,
   input  logic [INSTR_W-1:0]   in_instr,
   input  logic [AW-1:0]        in_pc,
   input  logic [XLEN-1:0]      ra_val,
   input  logic [XLEN-1:0]      rb_val,
   input  logic [VW-1:0]        vs_val,
   input  logic                 resv_enable,
   input  logic                 resv_any_active,
   output logic [REG_IDX_W-1:0] fld_vs,
   output logic [REG_IDX_W-1:0] fld_ra,
   output logic [REG_IDX_W-1:0] fld_rb,
   output logic                 mem_valid,
   input  logic                 mem_ready,
   output logic [AW-1:0]        mem_addr,
   output logic [VW-1:0]        mem_data,
   output logic [VW/8-1:0]      mem_strb,
   output logic                 inv_valid,
   output logic [AW-1:0]        inv_addr,
   output logic                 done_valid,
   output logic                 done_illegal,
   output logic [AW-1:0]        done_next_pc
);
   localparam int SB       = VW / 8;
   localparam int PC_STEP  = INSTR_W / 8;

   logic          match;
   logic [AW-1:0] ea;
   logic [AW-1:0] line_c, elem_c;
   logic [VW-1:0] data_c;
   logic [SB-1:0] strb_c;
   logic          accept, wr_fire;

   logic          pend_q, inv_arm_q;
   logic [AW-1:0] line_q, elem_q, pc_q;
   logic [VW-1:0] data_q;
   logic [SB-1:0] strb_q;
   logic          done_q, ill_q;
   logic [AW-1:0] done_pc_q;

   vhs_decode u_dec (
      .instr  (in_instr),
      .vs_idx (fld_vs),
      .ra_idx (fld_ra),
      .rb_idx (fld_rb),
      .match  (match)
   );

   vhs_agen #(.XLEN(XLEN), .AW(AW)) u_agen (
      .base_zero (fld_ra == '0),
      .base_val  (ra_val),
      .index_val (rb_val),
      .ea        (ea)
   );

   vhs_place #(.AW(AW), .VW(VW), .EB(EB), .ZERO_FILL(ZERO_FILL)) u_place (
      .ea        (ea),
      .vec       (vs_val),
      .line_addr (line_c),
      .elem_addr (elem_c),
      .data      (data_c),
      .strb      (strb_c)
   );

   assign in_ready = !pend_q;
   assign accept   = in_valid && in_ready;
   assign wr_fire  = pend_q && mem_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q    <= 1'b0;
         inv_arm_q <= 1'b0;
         line_q    <= '0;
         elem_q    <= '0;
         data_q    <= '0;
         strb_q    <= '0;
         pc_q      <= '0;
         done_q    <= 1'b0;
         ill_q     <= 1'b0;
         done_pc_q <= '0;
      end else begin
         done_q <= 1'b0;
         if (wr_fire) begin
            pend_q    <= 1'b0;
            done_q    <= 1'b1;
            ill_q     <= 1'b0;
            done_pc_q <= pc_q;
         end
         if (accept) begin
            if (match) begin
               pend_q    <= 1'b1;
               inv_arm_q <= resv_enable && resv_any_active;
               line_q    <= line_c;
               elem_q    <= elem_c;
               data_q    <= data_c;
               strb_q    <= strb_c;
               pc_q      <= in_pc + AW'(PC_STEP);
            end else begin
               done_q    <= 1'b1;
               ill_q     <= 1'b1;
               done_pc_q <= in_pc;
            end
         end
      end
   end

   assign mem_valid    = pend_q;
   assign mem_addr     = line_q;
   assign mem_data     = data_q;
   assign mem_strb     = strb_q;
   assign inv_valid    = wr_fire && inv_arm_q;
   assign inv_addr     = elem_q;
   assign done_valid   = done_q;
   assign done_illegal = ill_q;
   assign done_next_pc = done_pc_q;
endmodule

// File: rtl/vhs_store_unit_chk.sv
module vhs_store_unit_chk #(
   parameter int AW = 32,
   parameter int VW = 128,
   parameter int EB = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_ready,
   input logic          mem_valid,
   input logic          mem_ready,
   input logic [AW-1:0] mem_addr,
   input logic [VW-1:0] mem_data,
   input logic [VW/8-1:0] mem_strb,
   input logic          inv_valid,
   input logic [AW-1:0] inv_addr,
   input logic          done_valid,
   input logic          done_illegal
);
   localparam int SB   = VW / 8;
   localparam int OFFW = $clog2(SB);

   function automatic logic [SB-1:0] even_bits();
      logic [SB-1:0] m;
      for (int k = 0; k < SB; k++) m[k] = (k % 2 == 0);
      return m;
   endfunction
   localparam logic [SB-1:0] EVEN = even_bits();

   // R6: exactly one element's worth of enables
   a_r6_strobe_count: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> $countones(mem_strb) == EB);

   if (EB == 2) begin : g_pair
      // R6: the two enables form an even-aligned pair
      a_r6_strobe_pair: assert property (@(posedge clk) disable iff (!rst_n)
         mem_valid |-> ((mem_strb & EVEN) << 1) == (mem_strb & ~EVEN));
   end

   // R4: line-aligned write address
   a_r4_line_align: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> mem_addr[OFFW-1:0] == '0);

   // R9: request held steady while stalled
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr)
                                  && $stable(mem_data) && $stable(mem_strb));

   // R9: no new word while a write is pending
   a_r9_busy: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> !in_ready);

   // R8: invalidate only with the handshake, same line, half-aligned
   a_r8_inv_sync: assert property (@(posedge clk) disable iff (!rst_n)
      inv_valid |-> mem_valid && mem_ready && !inv_addr[0]
                    && inv_addr[AW-1:OFFW] == mem_addr[AW-1:OFFW]);

   // R10: a normal completion follows a write handshake
   a_r10_done_after: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid && !done_illegal |-> $past(mem_valid && mem_ready));

   // R11: an illegal completion never follows a write handshake
   a_r11_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid && done_illegal |-> !$past(mem_valid && mem_ready));
endmodule

bind vhs_store_unit vhs_store_unit_chk #(.AW(AW), .VW(VW), .EB(EB)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_ready     (in_ready),
   .mem_valid    (mem_valid),
   .mem_ready    (mem_ready),
   .mem_addr     (mem_addr),
   .mem_data     (mem_data),
   .mem_strb     (mem_strb),
   .inv_valid    (inv_valid),
   .inv_addr     (inv_addr),
   .done_valid   (done_valid),
   .done_illegal (done_illegal)
);

// File: tb/vhs_store_unit_bench.sv
module vhs_store_unit_bench;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic         in_ready;
   logic [31:0]  in_instr = '0;
   logic [31:0]  in_pc = '0;
   logic [63:0]  ra_val = '0, rb_val = '0;
   logic [127:0] vs_val = '0;
   logic         resv_enable = 1'b0, resv_any_active = 1'b0;
   logic [4:0]   fld_vs, fld_ra, fld_rb;
   logic         mem_valid;
   logic         mem_ready = 1'b1;
   logic [31:0]  mem_addr;
   logic [127:0] mem_data;
   logic [15:0]  mem_strb;
   logic         inv_valid;
   logic [31:0]  inv_addr;
   logic         done_valid, done_illegal;
   logic [31:0]  done_next_pc;

   vhs_store_unit u_vhs_store_unit (.*);

   typedef struct {
      logic [31:0]  addr;
      logic [127:0] data;
      logic [15:0]  strb;
      logic         inv;
      logic [31:0]  inv_addr;
   } wr_exp_t;
   typedef struct {
      logic        ill;
      logic [31:0] pc;
   } done_exp_t;

   wr_exp_t   wq[$];
   done_exp_t dq[$];
   int checks = 0, errors = 0, wr_exp = 0, wr_got = 0;
   bit stall_mode = 1'b0, finished = 1'b0;
   int cyc = 0;

   task automatic check(bit ok, string req, string what,
                        logic [127:0] act, logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   function automatic logic [31:0] mk(logic [5:0] op, logic [4:0] vs,
                                      logic [4:0] ra, logic [4:0] rb,
                                      logic [9:0] xo);
      return {op, vs, ra, rb, xo, 1'b0};
   endfunction

   // ready pattern, changed just after the edge
   always @(posedge clk) begin
      #1;
      cyc++;
      mem_ready = stall_mode ? (cyc % 3 == 0) : 1'b1;
   end

   // watchdog
   always @(posedge clk) begin
      if (cyc > 20000 && !finished) begin
         errors++;
         $display("FAIL R9 watchdog expired actual=%0d expected=%0d", cyc, 20000);
         report();
      end
   end

   // driver: computes the expected write from the requirements
   task automatic send(logic [31:0] instr, logic [63:0] ra, logic [63:0] rb,
                       logic [127:0] vs, logic [31:0] pc, bit ren, bit ract);
      logic        legal;
      logic [63:0] base;
      logic [31:0] ea;
      int          off;
      wr_exp_t     w;
      done_exp_t   d;
      legal = (instr[31:26] == 6'd31) && (instr[10:1] == 10'd167);   // R1
      base  = (instr[20:16] == 5'd0) ? 64'd0 : ra;                  // R2
      ea    = 32'(base + rb);                                        // R3
      off   = int'(ea[3:0] & 4'hE);
      w.addr = ea & 32'hFFFF_FFF0;                                   // R4
      w.strb = 16'h0003 << off;                                      // R6
      w.data = '0;                                                   // R5, R7
      w.data[8*off +: 8]     = vs[127-8*off -: 8];
      w.data[8*(off+1) +: 8] = vs[127-8*(off+1) -: 8];
      w.inv      = ren && ract;                                      // R8
      w.inv_addr = ea & 32'hFFFF_FFFE;
      d.ill = !legal;
      d.pc  = legal ? pc + 32'd4 : pc;                               // R10, R11
      @(posedge clk);
      #1;
      in_instr = instr; ra_val = ra; rb_val = rb; vs_val = vs; in_pc = pc;
      resv_enable = ren; resv_any_active = ract;
      in_valid = 1'b1;
      #1;
      check(fld_vs == instr[25:21] && fld_ra == instr[20:16] && fld_rb == instr[15:11],
            "R1", "register fields", {fld_vs, fld_ra, fld_rb},
            {instr[25:21], instr[20:16], instr[15:11]});
      do @(negedge clk); while (!in_ready);
      if (legal) begin wq.push_back(w); wr_exp++; end
      dq.push_back(d);
      @(posedge clk);
      #1;
      in_valid = 1'b0;
      resv_enable = 1'b0; resv_any_active = 1'b0;
      ra_val = '1; rb_val = '1; vs_val = '1;
   endtask

   // monitor
   logic         stall_seen = 1'b0;
   logic [31:0]  st_addr;
   logic [127:0] st_data;
   logic [15:0]  st_strb;
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (stall_seen) begin
            check(mem_valid && mem_addr == st_addr && mem_data == st_data
                  && mem_strb == st_strb, "R9", "request held while stalled",
                  mem_data, st_data);
         end
         stall_seen = mem_valid && !mem_ready;
         st_addr = mem_addr; st_data = mem_data; st_strb = mem_strb;
         if (mem_valid && in_ready)
            check(1'b0, "R9", "in_ready while pending", in_ready, 0);
         if (mem_valid && mem_ready) begin
            wr_got++;
            if (wq.size() == 0) begin
               check(1'b0, "R11", "unexpected write", mem_addr, 0);
            end else begin
               wr_exp_t w;
               w = wq.pop_front();
               check(mem_addr == w.addr, "R4", "line address", mem_addr, w.addr);
               check(mem_strb == w.strb, "R6", "strobe", mem_strb, w.strb);
               check(mem_data == w.data, "R7", "data placement (R5 slot)", mem_data, w.data);
               check(inv_valid == w.inv, "R8", "invalidate pulse", inv_valid, w.inv);
               if (w.inv)
                  check(inv_addr == w.inv_addr, "R8", "invalidate address", inv_addr, w.inv_addr);
            end
         end else if (inv_valid) begin
            check(1'b0, "R8", "stray invalidate", inv_valid, 0);
         end
         if (done_valid) begin
            if (dq.size() == 0) begin
               check(1'b0, "R10", "unexpected completion", done_next_pc, 0);
            end else begin
               done_exp_t d;
               d = dq.pop_front();
               check(done_illegal == d.ill, d.ill ? "R11" : "R10", "illegal flag",
                     done_illegal, d.ill);
               check(done_next_pc == d.pc, d.ill ? "R11" : "R10", "next pc",
                     done_next_pc, d.pc);
            end
         end
      end
   end

   localparam logic [127:0] V1 = 128'hA1B2_C3D4_E5F6_0718_293A_4B5C_6D7E_8F90;
   localparam logic [127:0] V2 = 128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0;

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check(in_ready && !mem_valid && !inv_valid && !done_valid, "R12", "reset state",
            {in_ready, mem_valid, inv_valid, done_valid}, 4'b1000);

      send(32'h7C00_014E, 64'h55, 64'h1000, V1, 32'h100, 0, 0);           // R1 ra=0 -> ea 0x1000
      send(mk(31, 3, 4, 5, 167), 64'h2000, 64'hF, V1, 32'h104, 1, 1);     // R6 slot 7, R8
      send(mk(31, 7, 9, 2, 167) | 32'h1, 64'h3000, 64'h3, V2, 32'h108, 1, 1); // R1 bit0 ignored, odd EA
      send(mk(31, 1, 0, 6, 167), 64'hDEAD, 64'h4006, V2, 32'h10C, 0, 1);  // R2
      send(mk(31, 2, 8, 6, 167), 64'hFFFF_FFFF_FFFF_FFF8, 64'h10, V1, 32'h110, 1, 0); // R3 wrap
      send(mk(31, 2, 8, 6, 167), 64'h0000_0005_0000_1230, 64'hA, V2, 32'h114, 0, 0);  // R3 trunc
      send(mk(31, 2, 8, 6, 166), 64'h100, 64'h2, V1, 32'h118, 1, 1);     // R11 bad XO
      send(mk(30, 2, 8, 6, 167), 64'h100, 64'h2, V1, 32'h11C, 1, 1);     // R11 bad primary
      stall_mode = 1'b1;
      send(mk(31, 4, 3, 2, 167), 64'h7770, 64'h5, V1, 32'h120, 1, 1);    // R9 stalled
      send(mk(31, 4, 3, 2, 167), 64'h8880, 64'hC, V2, 32'h124, 0, 0);    // R9 back-to-back
      send(mk(31, 4, 3, 2, 167), 64'h9990, 64'h9, V2, 32'h128, 1, 1);
      stall_mode = 1'b0;
      send(mk(31, 4, 3, 2, 167), 64'hAAA0, 64'hE, V1, 32'h12C, 1, 1);

      for (int i = 0; i < 50 && (wq.size() != 0 || dq.size() != 0); i++)
         @(negedge clk);
      repeat (3) @(negedge clk);
      check(wq.size() == 0 && dq.size() == 0, "R10", "all results seen",
            wq.size() + dq.size(), 0);
      check(wr_got == wr_exp, "R11", "write count", wr_got, wr_exp);
      report();
   end
endmodule